// File: doc/BRIEF.md
# Saturating Doubling Add/Subtract Execute Slice

This block is one execute slice of a processor pipeline. It recognises two instructions, a doubling saturating add and a doubling saturating subtract, in either of two encodings: a classic 32-bit word or a compact form made of two halfwords. It reports which source registers the instruction names. The caller looks those registers up and feeds their values back in the same cycle. The slice then clamps twice the first operand to the signed 32-bit range and either adds that clamped value to the second operand or subtracts it from the second operand, again with clamping.

On the next clock edge the slice registers four things: the destination index, the result, a legality bit, and a write enable. The write enable is qualified by the condition-pass input. A sticky saturation flag gathers overflow from both arithmetic stages. Only a dedicated clear input or reset brings that flag back to zero.

When `compact_i` is high, the first halfword is `insn_i[31:16]` and the second halfword is `insn_i[15:0]`.

Top module: `sat_dbl_unit`

## Requirements
- R1: Classic form (`compact_i`=0) is legal when bits [7:4]=0101, bits [11:8]=0000 and bits [27:20] are 0x14 (add) or 0x16 (subtract). In this form the destination is [15:12], the doubled register is [19:16] and the other register is [3:0].
- R2: Compact form (`compact_i`=1) is legal when the first halfword [15:4] is 0xFA8 and the second halfword ANDed with 0xF0F0 gives 0xF090 (add) or 0xF0B0 (subtract). In this form the doubled register is first-halfword [3:0], the destination is second-halfword [11:8] and the other register is second-halfword [3:0].
- R3: A classic instruction naming register 15 in any field is illegal. A compact instruction naming register 13 or 15 in any field is illegal. An illegal or unmatched word gives `legal_o`=0, `wen_o`=0 and `result_o`=0, and it leaves the flag unchanged.
- R4: The doubled value D is the signed 32-bit clamp of Rn+Rn.
- R5: For the add instruction, `result_o` is the signed clamp of Rm+D.
- R6: For the subtract instruction, `result_o` is the signed clamp of Rm−D.
- R7: Positive overflow clamps to 0x7FFFFFFF. Negative overflow clamps to 0x80000000.
- R8: All outputs except the source indices are registered one cycle after the inputs. `wen_o` equals `legal_o` ANDed with `cond_pass_i`. The result is still produced when the condition fails.
- R9: When an instruction is legal and its condition passes, overflow in the doubling stage or in the final stage sets `sat_flag_o`. The flag then stays set. Without a passing condition the flag is never set.
- R10: When `flag_clr_i` is high, `sat_flag_o` is 0 after the next edge, even if an overflow happens in that same cycle.
- R11: With `rst_n` low at a clock edge, every registered output becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| compact_i | input | 1 | 1 selects the two-halfword encoding |
| insn_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | Condition check result for this instruction |
| rn_val_i | input | 32 | Value of the register that is doubled |
| rm_val_i | input | 32 | Value of the other source register |
| flag_clr_i | input | 1 | Clears the sticky saturation flag |
| rn_idx_o | output | 4 | Decoded index of the doubled register (combinational) |
| rm_idx_o | output | 4 | Decoded index of the other register (combinational) |
| legal_o | output | 1 | Registered: instruction matched and register choice allowed |
| wen_o | output | 1 | Registered write enable |
| dst_o | output | 4 | Registered destination index |
| result_o | output | 32 | Registered result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
Operand pairs are chosen so that each saturation source shows up on its own. One pair stays in range. One pair saturates only in the doubling stage. One pair doubles exactly to the most negative value and overflows only in the subtraction. One pair overflows only when the in-range double is added. These cases separate a missing first clamp, a missing second clamp and a wrong clamp direction. Instruction words differ from a legal word in a single field, in a register number, or in the selected encoding. This shows whether each match term and each register restriction is checked on its own. Condition-fail, clear-with-overflow and reset cycles show whether the write enable and the flag are gated correctly.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
  localparam int IDX_W = 4;

  typedef enum logic {
    OP_DADD = 1'b0,
    OP_DSUB = 1'b1
  } dop_e;

  typedef struct packed {
    logic             ok;
    dop_e             op;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
  } dec_t;
endpackage

// File: rtl/sdu_fmt_dec.sv
module sdu_fmt_dec
  import sdu_pkg::*;
#(
  parameter bit COMPACT = 1'b0
) (
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  generate
    if (COMPACT) begin : g_compact
      logic [15:0] hw0, hw1;
      logic        is_add, is_sub, bad_reg;

      function automatic logic forbidden(input logic [IDX_W-1:0] r);
        return (r == 4'd13) || (r == 4'd15);
      endfunction

      assign hw0 = insn_i[31:16];
      assign hw1 = insn_i[15:0];

      always_comb begin
        is_add  = (hw0[15:4] == 12'hFA8) && ((hw1 & 16'hF0F0) == 16'hF090);
        is_sub  = (hw0[15:4] == 12'hFA8) && ((hw1 & 16'hF0F0) == 16'hF0B0);
        dec_o.rn  = hw0[3:0];
        dec_o.dst = hw1[11:8];
        dec_o.rm  = hw1[3:0];
        bad_reg = forbidden(dec_o.rn) || forbidden(dec_o.dst) || forbidden(dec_o.rm);
        dec_o.op  = is_sub ? OP_DSUB : OP_DADD;
        dec_o.ok  = (is_add || is_sub) && !bad_reg;
      end
    end else begin : g_classic
      logic is_add, is_sub, fixed_ok, bad_reg;

      always_comb begin
        fixed_ok = (insn_i[11:8] == 4'b0000) && (insn_i[7:4] == 4'b0101);
        is_add   = fixed_ok && (insn_i[27:20] == 8'b0001_0100);
        is_sub   = fixed_ok && (insn_i[27:20] == 8'b0001_0110);
        dec_o.dst = insn_i[15:12];
        dec_o.rn  = insn_i[19:16];
        dec_o.rm  = insn_i[3:0];
        bad_reg  = (dec_o.dst == 4'd15) || (dec_o.rn == 4'd15) || (dec_o.rm == 4'd15);
        dec_o.op  = is_sub ? OP_DSUB : OP_DADD;
        dec_o.ok  = (is_add || is_sub) && !bad_reg;
      end
    end
  endgenerate
endmodule

// File: rtl/sdu_sat_dp.sv
module sdu_sat_dp
  import sdu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rn_val_i,
  input  logic [DW-1:0] rm_val_i,
  input  dop_e          op_i,
  output logic [DW-1:0] dbl_o,
  output logic          dbl_ovf_o,
  output logic [DW-1:0] res_o,
  output logic          res_ovf_o
);
  localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  // Returns {overflow, clamped value} of a +/- b in DW-bit two's complement.
  function automatic logic [DW:0] clamp_op(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input logic          sub);
    logic [DW:0] wide;
    logic        ovf;
    wide = sub ? ({a[DW-1], a} - {b[DW-1], b})
               : ({a[DW-1], a} + {b[DW-1], b});
    ovf  = wide[DW] ^ wide[DW-1];
    if (!ovf)          return {1'b0, wide[DW-1:0]};
    else if (wide[DW]) return {1'b1, NEG_LIM};
    else               return {1'b1, POS_LIM};
  endfunction

  logic [DW:0] stage1, stage2;

  always_comb begin
    stage1    = clamp_op(rn_val_i, rn_val_i, 1'b0);
    dbl_ovf_o = stage1[DW];
    dbl_o     = stage1[DW-1:0];
    stage2    = clamp_op(rm_val_i, dbl_o, op_i == OP_DSUB);
    res_ovf_o = stage2[DW];
    res_o     = stage2[DW-1:0];
  end
endmodule

// File: rtl/sat_dbl_unit.sv
module sat_dbl_unit
  import sdu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 compact_i,
  input  logic [31:0]          insn_i,
  input  logic                 cond_pass_i,
  input  logic [DW-1:0]        rn_val_i,
  input  logic [DW-1:0]        rm_val_i,
  input  logic                 flag_clr_i,
  output logic [IDX_W-1:0]     rn_idx_o,
  output logic [IDX_W-1:0]     rm_idx_o,
  output logic                 legal_o,
  output logic                 wen_o,
  output logic [IDX_W-1:0]     dst_o,
  output logic [DW-1:0]        result_o,
  output logic                 sat_flag_o
);
  localparam int NFMT = 2;
  localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  dec_t          dec_fmt [NFMT];
  dec_t          dec_sel;
  logic [DW-1:0] dbl_val, res_val;
  logic          dbl_ovf, res_ovf;
  logic          sat_event;

  genvar g;
  generate
    for (g = 0; g < NFMT; g++) begin : g_fmt
      sdu_fmt_dec #(.COMPACT(g == 1)) u_dec (
        .insn_i (insn_i),
        .dec_o  (dec_fmt[g])
      );
    end
  endgenerate

  assign dec_sel  = compact_i ? dec_fmt[1] : dec_fmt[0];
  assign rn_idx_o = dec_sel.rn;
  assign rm_idx_o = dec_sel.rm;

  sdu_sat_dp #(.DW(DW)) u_dp (
    .rn_val_i  (rn_val_i),
    .rm_val_i  (rm_val_i),
    .op_i      (dec_sel.op),
    .dbl_o     (dbl_val),
    .dbl_ovf_o (dbl_ovf),
    .res_o     (res_val),
    .res_ovf_o (res_ovf)
  );

  assign sat_event = dec_sel.ok && cond_pass_i && (dbl_ovf || res_ovf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      legal_o    <= 1'b0;
      wen_o      <= 1'b0;
      dst_o      <= '0;
      result_o   <= '0;
      sat_flag_o <= 1'b0;
    end else begin
      legal_o    <= dec_sel.ok;
      wen_o      <= dec_sel.ok && cond_pass_i;
      dst_o      <= dec_sel.ok ? dec_sel.dst : '0;
      result_o   <= dec_sel.ok ? res_val : '0;
      if (flag_clr_i)     sat_flag_o <= 1'b0;
      else if (sat_event) sat_flag_o <= 1'b1;
    end
  end

  AST_WEN_NEEDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wen_o |-> legal_o); // R8
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_sel.ok |=> (!legal_o && !wen_o)); // R3
  AST_DBL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_ovf |-> (dbl_val == POS_LIM || dbl_val == NEG_LIM)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag_o && !flag_clr_i) |=> sat_flag_o); // R9
  AST_FLAG_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_flag_o && !cond_pass_i) |=> !sat_flag_o); // R9
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i |=> !sat_flag_o); // R10
endmodule

// File: tb/sat_dbl_unit_test.sv
module sat_dbl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        compact_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        cond_pass_i = 1'b0;
  logic [31:0] rn_val_i = '0, rm_val_i = '0;
  logic        flag_clr_i = 1'b0;
  logic [3:0]  rn_idx_o, rm_idx_o, dst_o;
  logic        legal_o, wen_o, sat_flag_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sat_dbl_unit uut (
    .clk(clk), .rst_n(rst_n), .compact_i(compact_i), .insn_i(insn_i),
    .cond_pass_i(cond_pass_i), .rn_val_i(rn_val_i), .rm_val_i(rm_val_i),
    .flag_clr_i(flag_clr_i), .rn_idx_o(rn_idx_o), .rm_idx_o(rm_idx_o),
    .legal_o(legal_o), .wen_o(wen_o), .dst_o(dst_o), .result_o(result_o),
    .sat_flag_o(sat_flag_o)
  );

  typedef struct packed {
    logic        cmp;
    logic [31:0] insn;
    logic [31:0] n;
    logic [31:0] m;
    logic        cond;
    logic        sub;
    logic        legal;
    logic [3:0]  dst;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hE1421053, 32'h00000005, 32'h0000000A, 1'b1, 1'b0, 1'b1, 4'd1},
    '{1'b0, 32'hE1664057, 32'h00000005, 32'h0000000A, 1'b1, 1'b1, 1'b1, 4'd4},
    '{1'b0, 32'hE1410052, 32'h40000000, 32'h00000000, 1'b1, 1'b0, 1'b1, 4'd0},
    '{1'b0, 32'hE1632054, 32'hC0000000, 32'h00000000, 1'b1, 1'b1, 1'b1, 4'd2},
    '{1'b1, 32'hFA85F697, 32'h30000000, 32'h30000000, 1'b1, 1'b0, 1'b1, 4'd6},
    '{1'b1, 32'hFA88F9BA, 32'h80000000, 32'h00000005, 1'b1, 1'b1, 1'b1, 4'd9},
    '{1'b0, 32'hE1465057, 32'h40000000, 32'h00000000, 1'b0, 1'b0, 1'b1, 4'd5},
    '{1'b0, 32'hE141F052, 32'h40000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd0},
    '{1'b1, 32'hFA8DF197, 32'h40000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd0},
    '{1'b0, 32'hE14D3052, 32'hFFFFFFF9, 32'h00000064, 1'b1, 1'b0, 1'b1, 4'd3},
    '{1'b0, 32'hE1421043, 32'h40000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd0},
    '{1'b1, 32'hFA85F6A7, 32'h40000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd0},
    '{1'b1, 32'hFA82FCB3, 32'h00000001, 32'h80000000, 1'b1, 1'b1, 1'b1, 4'd12},
    '{1'b1, 32'hE1421053, 32'h40000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd0},
    '{1'b1, 32'hFA85F697, 32'hFFFFFFFF, 32'h00000001, 1'b1, 1'b0, 1'b1, 4'd6}
  };

  function automatic longint lim(input longint v);
    if (v > 64'sd2147483647)  return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  // Reference model: returns {overflow, result}
  function automatic logic [32:0] model(input logic [31:0] n, input logic [31:0] m,
                                        input logic sub);
    longint ln, lm, d, r, rc;
    logic   ov;
    ln = longint'($signed(n));
    lm = longint'($signed(m));
    d  = lim(ln * 2);
    ov = (d != ln * 2);
    r  = sub ? lm - d : lm + d;
    rc = lim(r);
    ov = ov || (rc != r);
    return {ov, rc[31:0]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic cmp, input logic [31:0] insn, input logic [31:0] n,
                       input logic [31:0] m, input logic cond, input logic clr);
    compact_i = cmp; insn_i = insn; rn_val_i = n; rm_val_i = m;
    cond_pass_i = cond; flag_clr_i = clr;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [32:0] mr;
    logic        ef;
    // R11: reset state
    repeat (2) @(negedge clk);
    chk("R11", "legal after reset", {31'b0, legal_o}, 32'd0);
    chk("R11", "wen after reset", {31'b0, wen_o}, 32'd0);
    chk("R11", "result after reset", result_o, 32'd0);
    chk("R11", "flag after reset", {31'b0, sat_flag_o}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1);
      @(negedge clk);
      drive(VECS[i].cmp, VECS[i].insn, VECS[i].n, VECS[i].m, VECS[i].cond, 1'b0);
      #1;
      if (VECS[i].legal) begin
        // R1 / R2: source index fields
        chk(VECS[i].cmp ? "R2" : "R1", "rn index",
            {28'b0, rn_idx_o}, {28'b0, VECS[i].cmp ? VECS[i].insn[19:16] : VECS[i].insn[19:16]});
        chk(VECS[i].cmp ? "R2" : "R1", "rm index", {28'b0, rm_idx_o}, {28'b0, VECS[i].insn[3:0]});
      end
      mr = model(VECS[i].n, VECS[i].m, VECS[i].sub);
      ef = VECS[i].legal && VECS[i].cond && mr[32];
      @(negedge clk);
      chk(VECS[i].cmp ? "R2/R3" : "R1/R3", "legal", {31'b0, legal_o}, {31'b0, VECS[i].legal});
      chk("R8", "wen", {31'b0, wen_o}, {31'b0, VECS[i].legal && VECS[i].cond});
      if (VECS[i].legal) begin
        chk(VECS[i].cmp ? "R2" : "R1", "dst", {28'b0, dst_o}, {28'b0, VECS[i].dst});
        chk(VECS[i].sub ? "R6/R4/R7" : "R5/R4/R7", "result", result_o, mr[31:0]);
      end else begin
        chk("R3", "result of illegal", result_o, 32'd0);
      end
      chk("R9", "flag", {31'b0, sat_flag_o}, {31'b0, ef});
    end

    // R9: flag stays set across a non-overflowing op
    drive(1'b0, 32'hE1410052, 32'h40000000, 32'h0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9", "flag set by doubling", {31'b0, sat_flag_o}, 32'd1);
    drive(1'b0, 32'hE1421053, 32'h5, 32'hA, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9", "flag sticky", {31'b0, sat_flag_o}, 32'd1);
    chk("R5", "in-range add", result_o, 32'd20);

    // R10: clear wins over a same-cycle overflow
    drive(1'b0, 32'hE1410052, 32'h40000000, 32'h0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R10", "clear beats set", {31'b0, sat_flag_o}, 32'd0);
    chk("R7", "positive clamp", result_o, 32'h7FFFFFFF);

    // R11: reset mid-run clears everything
    drive(1'b0, 32'hE1410052, 32'h40000000, 32'h0, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "flag on reset", {31'b0, sat_flag_o}, 32'd0);
    chk("R11", "legal on reset", {31'b0, legal_o}, 32'd0);
    chk("R11", "result on reset", result_o, 32'd0);
    chk("R11", "wen on reset", {31'b0, wen_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule